// File: doc/BRIEF.md
# Multifunction 32-bit ALU

This block is the arithmetic and logic unit of a small load/store processor. It is purely combinational. Two operands, `opX` and `opY`, pass through four result sources: a shared adder, a set-less-than stage driven by that same adder, a bitwise logic unit and a barrel shifter. A two-bit class code picks which source drives `result`. The same barrel-shifter class also covers load-upper-immediate.

A small decoder turns the raw control inputs into a packed set of strobes. The datapath consumes those strobes. Alongside the result the block reports signed overflow, for the arithmetic class only, and a zero flag. The zero flag is set when every result bit is clear. It can feed branch logic or condition checks.

Top module: `multiAlu`

## Requirements
- R1: With `fnClass`=2'b10 and `subSel`=0, `result` equals `opX + opY` modulo 2^32.
- R2: With `fnClass`=2'b10 and `subSel`=1, `result` equals `opX - opY` modulo 2^32, formed by inverting `opY` and forcing the carry-in to 1.
- R3: `ovfl` is 1 only when `fnClass`=2'b10 and the selected addition or subtraction overflows as a two's-complement operation. It is 0 for every other class.
- R4: With `fnClass`=2'b01, `result` is 1 when `opX` < `opY` as signed numbers and 0 otherwise, with bits 31..1 cleared. The answer is correct even when `opX - opY` overflows, and it does not depend on `subSel`.
- R5: With `fnClass`=2'b11, `result` is the bitwise function chosen by `logicFn`: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR.
- R6: With `fnClass`=2'b00 and `shiftFn`=2'b01, `result` is `opY` shifted left by the shift amount, with zeros filling from the bottom.
- R7: With `fnClass`=2'b00 and `shiftFn`=2'b10, `result` is `opY` shifted right logically by the shift amount, with zeros filling from the top.
- R8: With `fnClass`=2'b00 and `shiftFn`=2'b11, `result` is `opY` shifted right by the shift amount, with copies of `opY[31]` filling from the top.
- R9: The shift amount is `constShamt` when `varShamtSel`=0. It is `opX[4:0]` when `varShamtSel`=1, and `opX[31:5]` has no effect on the shift.
- R10: With `fnClass`=2'b00 and `shiftFn`=2'b00, `result` is `{opY[15:0], 16'h0000}`, and `opY[31:16]` has no effect.
- R11: `zero` is 1 exactly when all 32 bits of `result` are 0, in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opX | input | 32 | First operand; low 5 bits are the variable shift amount |
| opY | input | 32 | Second operand; the shifted value and the upper-immediate source |
| constShamt | input | 5 | Shift amount taken from the instruction |
| fnClass | input | 2 | Result source: 00 shift/upper-immediate, 01 set-less, 10 adder, 11 logic |
| subSel | input | 1 | 0 add, 1 subtract (arithmetic class) |
| logicFn | input | 2 | 00 AND, 01 OR, 10 XOR, 11 NOR |
| shiftFn | input | 2 | 00 upper-immediate, 01 left, 10 logical right, 11 arithmetic right |
| varShamtSel | input | 1 | 0 takes the amount from constShamt, 1 takes it from opX[4:0] |
| result | output | 32 | Selected result |
| ovfl | output | 1 | Signed overflow of the arithmetic class |
| zero | output | 1 | Set when result is all zeros |

## Verification
No register lies between any input and `result`, `ovfl` or `zero`, so each output is due in the same cycle its stimulus is applied. The bench changes inputs just after a rising edge and reads all three outputs at the next falling edge, half a period later. By then the combinational paths have settled, and no sample can race an input update. Every vector is compared against a bench model built from the requirements using plain integer arithmetic and shift operators.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [1:0] {
    CLS_SHIFT   = 2'b00,
    CLS_SETLESS = 2'b01,
    CLS_ARITH   = 2'b10,
    CLS_LOGIC   = 2'b11
  } fnClass_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOR = 2'b11
  } logicOp_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_ARITH = 2'b11
  } shiftOp_e;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic     pickShift;
    logic     pickSetLess;
    logic     pickSum;
    logic     pickLogic;
    logic     doSubtract;
    logicOp_e logicOp;
    logic     shLeft;
    logic     shArith;
    logic     pickUpperImm;
    logic     useVarAmt;
    logic     flagOvfl;
  } aluStrobes_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [1:0]  fnClassIn,
  input  logic        subSel,
  input  logic [1:0]  logicFnIn,
  input  logic [1:0]  shiftFnIn,
  input  logic        varShamtSel,
  output aluStrobes_t strobes
);

  fnClass_e cls;
  shiftOp_e shOp;

  assign cls  = fnClass_e'(fnClassIn);
  assign shOp = shiftOp_e'(shiftFnIn);

  always_comb begin
    strobes = '0;
    unique case (cls)
      CLS_SHIFT:   strobes.pickShift   = 1'b1;
      CLS_SETLESS: strobes.pickSetLess = 1'b1;
      CLS_ARITH:   strobes.pickSum     = 1'b1;
      CLS_LOGIC:   strobes.pickLogic   = 1'b1;
    endcase
    // set-less always compares through a subtraction
    strobes.doSubtract   = (cls == CLS_SETLESS) ? 1'b1 : subSel;
    strobes.logicOp      = logicOp_e'(logicFnIn);
    strobes.shLeft       = (shOp == SH_LEFT);
    strobes.shArith      = (shOp == SH_ARITH);
    strobes.pickUpperImm = (shOp == SH_NONE);
    strobes.useVarAmt    = varShamtSel;
    strobes.flagOvfl     = (cls == CLS_ARITH);
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             ovflRaw
);

  logic [WIDTH-1:0] bIn;
  logic [WIDTH-1:0] lowSum;
  logic             carryIntoMsb;
  logic             carryOutMsb;
  logic             msbSum;

  always_comb begin
    bIn          = subtract ? ~addB : addB;
    // lower bits plus carry-in; bit WIDTH-1 of lowSum is the carry into the MSB
    lowSum       = {1'b0, addA[WIDTH-2:0]} + {1'b0, bIn[WIDTH-2:0]}
                 + {{(WIDTH-1){1'b0}}, subtract};
    carryIntoMsb = lowSum[WIDTH-1];
    msbSum       = addA[WIDTH-1] ^ bIn[WIDTH-1] ^ carryIntoMsb;
    carryOutMsb  = (addA[WIDTH-1] & bIn[WIDTH-1])
                 | (carryIntoMsb & (addA[WIDTH-1] ^ bIn[WIDTH-1]));
    sum          = {msbSum, lowSum[WIDTH-2:0]};
    ovflRaw      = carryIntoMsb ^ carryOutMsb;

    if (!subtract)
      assert_sum_R1: assert (sum == addA + addB)
        else $error("adder sum mismatch");
    else
      assert_diff_R2: assert (sum == addA - addB)
        else $error("adder difference mismatch");
  end

endmodule

// File: rtl/aluShifter.sv
module aluShifter #(
  parameter int WIDTH   = 32,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   shIn,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               shLeft,
  input  logic               shArith,
  output logic [WIDTH-1:0]   shOut
);

  logic [SHAMT_W:0][WIDTH-1:0] stage;
  logic                        fillBit;

  assign fillBit  = shArith & shIn[WIDTH-1];
  assign stage[0] = shIn;

  for (genvar k = 0; k < SHAMT_W; k++) begin : gStage
    localparam int STEP = 1 << k;
    assign stage[k+1] = !shAmt[k] ? stage[k] :
                        shLeft    ? {stage[k][WIDTH-1-STEP:0], {STEP{1'b0}}} :
                                    {{STEP{fillBit}}, stage[k][WIDTH-1:STEP]};
  end

  assign shOut = stage[SHAMT_W];

  always_comb begin
    if (!shLeft && shArith && shIn[WIDTH-1])
      assert_sign_fill_R8: assert (shOut[WIDTH-1])
        else $error("arithmetic right shift lost the sign");
    if (!shLeft && !shArith && (shAmt != '0))
      assert_zero_fill_R7: assert (!shOut[WIDTH-1])
        else $error("logical right shift did not clear the top bit");
  end

endmodule

// File: rtl/aluLogic.sv
module aluLogic
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] lgA,
  input  logic [WIDTH-1:0] lgB,
  input  logicOp_e         lgOp,
  output logic [WIDTH-1:0] lgOut
);

  always_comb begin
    unique case (lgOp)
      LOP_AND: lgOut = lgA & lgB;
      LOP_OR:  lgOut = lgA | lgB;
      LOP_XOR: lgOut = lgA ^ lgB;
      LOP_NOR: lgOut = ~(lgA | lgB);
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   opX,
  input  logic [WIDTH-1:0]   opY,
  input  logic [SHAMT_W-1:0] constShamt,
  input  aluStrobes_t        strobes,
  output logic [WIDTH-1:0]   result,
  output logic               ovfl,
  output logic               zero
);

  localparam int IMM_W = WIDTH / 2;

  logic [WIDTH-1:0]   sum;
  logic               ovflRaw;
  logic               setLessBit;
  logic [SHAMT_W-1:0] shAmt;
  logic [WIDTH-1:0]   shOut;
  logic [WIDTH-1:0]   lgOut;
  logic [WIDTH-1:0]   upperImm;

  assign shAmt    = strobes.useVarAmt ? opX[SHAMT_W-1:0] : constShamt;
  assign upperImm = {opY[IMM_W-1:0], {(WIDTH-IMM_W){1'b0}}};

  aluAdder #(.WIDTH(WIDTH)) uAdder (
    .addA     (opX),
    .addB     (opY),
    .subtract (strobes.doSubtract),
    .sum      (sum),
    .ovflRaw  (ovflRaw)
  );

  aluShifter #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) uShifter (
    .shIn    (opY),
    .shAmt   (shAmt),
    .shLeft  (strobes.shLeft),
    .shArith (strobes.shArith),
    .shOut   (shOut)
  );

  aluLogic #(.WIDTH(WIDTH)) uLogic (
    .lgA   (opX),
    .lgB   (opY),
    .lgOp  (strobes.logicOp),
    .lgOut (lgOut)
  );

  // sign of the difference, corrected when the subtraction overflowed
  assign setLessBit = sum[WIDTH-1] ^ ovflRaw;

  always_comb begin
    if (strobes.pickShift)
      result = strobes.pickUpperImm ? upperImm : shOut;
    else if (strobes.pickSetLess)
      result = {{(WIDTH-1){1'b0}}, setLessBit};
    else if (strobes.pickSum)
      result = sum;
    else
      result = lgOut;

    if (strobes.pickSetLess)
      assert_setless_R4: assert (result[0] == ($signed(opX) < $signed(opY)))
        else $error("set-less answer wrong");
  end

  always_comb begin
    logic signOvfl;
    ovfl = strobes.flagOvfl & ovflRaw;
    signOvfl = strobes.doSubtract
             ? ((opX[WIDTH-1] != opY[WIDTH-1]) && (sum[WIDTH-1] != opX[WIDTH-1]))
             : ((opX[WIDTH-1] == opY[WIDTH-1]) && (sum[WIDTH-1] != opX[WIDTH-1]));
    assert_ovfl_class_R3: assert (ovfl == (strobes.flagOvfl && signOvfl))
      else $error("overflow flag wrong");
  end

  assign zero = ~|result;

endmodule

// File: rtl/multiAlu.sv
module multiAlu
  import aluPkg::*;
#(
  parameter  int WIDTH   = 32,
  localparam int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   opX,
  input  logic [WIDTH-1:0]   opY,
  input  logic [SHAMT_W-1:0] constShamt,
  input  logic [1:0]         fnClass,
  input  logic               subSel,
  input  logic [1:0]         logicFn,
  input  logic [1:0]         shiftFn,
  input  logic               varShamtSel,
  output logic [WIDTH-1:0]   result,
  output logic               ovfl,
  output logic               zero
);

  aluStrobes_t strobes;

  aluControl uControl (
    .fnClassIn   (fnClass),
    .subSel      (subSel),
    .logicFnIn   (logicFn),
    .shiftFnIn   (shiftFn),
    .varShamtSel (varShamtSel),
    .strobes     (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) uDatapath (
    .opX        (opX),
    .opY        (opY),
    .constShamt (constShamt),
    .strobes    (strobes),
    .result     (result),
    .ovfl       (ovfl),
    .zero       (zero)
  );

endmodule

// File: tb/sim_multiAlu.sv
module sim_multiAlu;

  logic        clk;
  logic [31:0] opX, opY;
  logic [4:0]  constShamt;
  logic [1:0]  fnClass, logicFn, shiftFn;
  logic        subSel, varShamtSel;
  logic [31:0] result;
  logic        ovfl, zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] rngState = 32'h1badf00d;

  multiAlu u0 (
    .opX(opX), .opY(opY), .constShamt(constShamt), .fnClass(fnClass),
    .subSel(subSel), .logicFn(logicFn), .shiftFn(shiftFn),
    .varShamtSel(varShamtSel), .result(result), .ovfl(ovfl), .zero(zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] nextRand();
    logic [31:0] s;
    s = rngState;
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    rngState = s;
    return s;
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one vector after a rising edge, sample at the falling edge.
  task automatic runVec(input string req, input logic [31:0] x, input logic [31:0] y,
                        input logic [4:0] cs, input logic [1:0] cls, input logic sub,
                        input logic [1:0] lf, input logic [1:0] sf, input logic vs);
    logic [31:0] expR;
    logic        expOv;
    logic [4:0]  amt;
    @(posedge clk);
    opX = x; opY = y; constShamt = cs; fnClass = cls; subSel = sub;
    logicFn = lf; shiftFn = sf; varShamtSel = vs;
    amt   = vs ? x[4:0] : cs;
    expOv = 1'b0;
    case (cls)
      2'b00: case (sf)
        2'b00: expR = {y[15:0], 16'h0000};
        2'b01: expR = y << amt;
        2'b10: expR = y >> amt;
        default: expR = $signed(y) >>> amt;
      endcase
      2'b01: expR = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      2'b10: begin
        expR  = sub ? (x - y) : (x + y);
        expOv = sub ? ((x[31] != y[31]) && (expR[31] != x[31]))
                    : ((x[31] == y[31]) && (expR[31] != x[31]));
      end
      default: case (lf)
        2'b00: expR = x & y;
        2'b01: expR = x | y;
        2'b10: expR = x ^ y;
        default: expR = ~(x | y);
      endcase
    endcase
    @(negedge clk);
    checkVal(req, "result", result, expR);
    checkVal("R3", "ovfl", {31'd0, ovfl}, {31'd0, expOv});
    checkVal("R11", "zero", {31'd0, zero}, {31'd0, (expR == 32'd0)});
  endtask

  function automatic string shiftReq(input logic [1:0] sf);
    case (sf)
      2'b00: return "R10";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic [31:0] corners [8];

  initial begin
    corners[0] = 32'h00000000; corners[1] = 32'h00000001;
    corners[2] = 32'h7fffffff; corners[3] = 32'h80000000;
    corners[4] = 32'hffffffff; corners[5] = 32'h12345678;
    corners[6] = 32'hfffe0001; corners[7] = 32'h00010000;
    opX = '0; opY = '0; constShamt = '0; fnClass = '0; subSel = 0;
    logicFn = '0; shiftFn = '0; varShamtSel = 0;

    // Idle vector: all-zero controls and operands (R10 / R11)
    runVec("R10", 32'h0, 32'h0, 5'd0, 2'b00, 0, 2'b00, 2'b00, 0);

    // Overflow corners (R1, R2, R3) and corrected set-less (R4)
    runVec("R1", 32'h7fffffff, 32'h00000001, 5'd0, 2'b10, 0, 2'b00, 2'b00, 0);
    runVec("R2", 32'h80000000, 32'h00000001, 5'd0, 2'b10, 1, 2'b00, 2'b00, 0);
    runVec("R4", 32'h80000000, 32'h00000001, 5'd0, 2'b01, 0, 2'b00, 2'b00, 0);
    runVec("R4", 32'h7fffffff, 32'hffffffff, 5'd0, 2'b01, 1, 2'b00, 2'b00, 0);
    // Upper half of opY ignored by upper-immediate (R10)
    runVec("R10", 32'h0, 32'hdead0000, 5'd3, 2'b00, 0, 2'b00, 2'b00, 0);

    // Corner pairs through arithmetic, set-less and logic classes
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        runVec("R1", corners[i], corners[j], 5'd0, 2'b10, 0, 2'b00, 2'b00, 0);
        runVec("R2", corners[i], corners[j], 5'd0, 2'b10, 1, 2'b00, 2'b00, 0);
        runVec("R4", corners[i], corners[j], 5'd0, 2'b01, 0, 2'b00, 2'b00, 0);
        runVec("R4", corners[i], corners[j], 5'd0, 2'b01, 1, 2'b00, 2'b00, 0);
        for (int f = 0; f < 4; f++)
          runVec("R5", corners[i], corners[j], 5'd0, 2'b11, 0, 2'(f), 2'b00, 0);
      end
    end

    // Every shift amount, function and amount source (R6..R10, R9)
    for (int p = 0; p < 3; p++) begin
      logic [31:0] yv;
      yv = (p == 0) ? 32'h80000000 : (p == 1) ? 32'hf0f0a5a5 : 32'h7fff1234;
      for (int sf = 0; sf < 4; sf++) begin
        for (int a = 0; a < 32; a++) begin
          runVec(shiftReq(2'(sf)), nextRand(), yv, 5'(a), 2'b00, 0, 2'b00, 2'(sf), 0);
          // variable source: junk in opX[31:5], opposite amount on constShamt
          runVec("R9", {nextRand() >> 5, 5'(a)}, yv, ~5'(a), 2'b00, 0, 2'b00, 2'(sf), 1);
        end
      end
    end

    // Mixed random vectors over all controls
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [1:0]  cls;
      r   = nextRand();
      cls = r[1:0];
      runVec(cls == 2'b00 ? shiftReq(r[7:6]) : cls == 2'b01 ? "R4" :
             cls == 2'b10 ? (r[2] ? "R2" : "R1") : "R5",
             nextRand(), (r[9] ? nextRand() : {16'h0, r[31:16]}),
             r[14:10], cls, r[2], r[5:4], r[7:6], r[8]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule